// File: doc/BRIEF.md
# Flash Page Programming Controller

This block sits in front of a behavioural flash array. Software does not write the array directly. It fills a one-page staging buffer with 32-bit writes. The buffer answers to every page address of the memory window, so a word lands in the same slot no matter which page address was used. Software then issues a keyed command naming a target page. The controller checks the key, the opcode, the page number and the region locks. It then runs a fixed-length operation, during which the ready status bit is low.

Besides plain programming, there are four other commands. Programming can also lock the page's region once it finishes. There are explicit lock and unlock commands for a region. A whole-array erase resets every word to all ones. A mode bit selects partial programming: without it, the target page is erased before the buffer is written. With it, the new data is ANDed into the old contents, so several passes can fill different words of one page. A mode bit also enables an interrupt that follows the ready status.

The bus side is a single valid/ready request channel with a registered read response. A request is taken on any clock edge where `req_valid` and `req_ready` are both high. The requester must hold the request stable until then. Register requests are never stalled. Memory-window requests are stalled while an operation runs. A read is answered by a one-cycle `rsp_valid` pulse on the edge after it is accepted. The response has no back-pressure.

Top module: `flashpg_top`

## Requirements
- R1: A word write to memory byte address A (0x000–0x1FF) stores into buffer slot (A/4) mod 16. A later program command writes slot k into word k of the page named by the command, whatever page address was used for the write.
- R2: A memory write whose size code is not word (req_size 0 = byte, 1 = halfword, 2 = word), or whose address is not word aligned, leaves the buffer unchanged.
- R3: Command register (0x204) layout: key 0x5A in bits 31:24, page in bits 15:8, opcode in bits 3:0, and bits 23:16 and 7:4 zero. A valid command clears status bit 0 (ready) from the next cycle. Ready stays low for exactly 32 cycles, and the array changes only when the operation ends.
- R4: `irq` is high exactly when ready is high and mode register (0x200) bit 0 is set.
- R5: A wrong key, non-zero reserved bits, an opcode outside {1,2,3,4,8}, or a page ≥ 8 on a page opcode sets status bit 1 (program error). In that case no operation starts.
- R6: Opcode 1 (program) or 2 (program and lock) aimed at a page whose region (page/2) is locked sets status bit 2 (lock error) and leaves the array unchanged. Opcode 3 locks the page's region and opcode 4 unlocks it. The lock bits read at status bits 19:16, one per region.
- R7: Opcode 8 sets every array word to 0xFFFFFFFF. If any region is locked, it is refused with a lock error instead.
- R8: Opcode 2 sets its region's lock bit when programming completes.
- R9: When mode bit 1 is clear, programming replaces the page with the buffer. When it is set, each page word becomes old AND buffer, so earlier data is kept.
- R10: A status read (0x208) returns the flags as they were, then clears bits 1 and 2.
- R11: A command written while ready is low is ignored and sets the program error flag.
- R12: Memory-window requests see `req_ready` low while an operation runs. Register requests always see it high. A memory read returns array word (A/4) mod 128 with `rsp_valid` one cycle after acceptance.
- R13: When a program operation completes, every buffer slot returns to 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address; bit 9 selects the register window |
| req_size | input | 2 | Access size code: 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Ready interrupt |

## Verification
A wrong internal state can show up at the ports in three ways. A wrong busy counter moves the rise of `irq` and ready away from the 32nd cycle after the command. A stale or corrupted buffer slot appears in the first readback of the programmed page. A lost or stuck error or lock bit appears in the very next status read. The erase-versus-merge choice and the buffer refill are each exposed by reading back, right after completion, words that only one of the alternatives would leave at all ones.

// File: rtl/flashpg_pkg.sv
package flashpg_pkg;

  typedef enum logic [3:0] {
    OP_PROG      = 4'h1,
    OP_PROG_LOCK = 4'h2,
    OP_LOCK      = 4'h3,
    OP_UNLOCK    = 4'h4,
    OP_ERASE_ALL = 4'h8
  } flash_op_e;

  localparam logic [7:0] CMD_KEY   = 8'h5A;
  localparam logic [1:0] SIZE_WORD = 2'd2;

  localparam logic [1:0] REG_MODE = 2'd0;
  localparam logic [1:0] REG_CMD  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;

  localparam int STAT_READY = 0;
  localparam int STAT_PERR  = 1;
  localparam int STAT_LERR  = 2;
  localparam int STAT_LOCK  = 16;

endpackage

// File: rtl/flashpg_latch.sv
module flashpg_latch #(
  parameter int PAGE_WORDS = 16,
  parameter int DW         = 32,
  localparam int IW        = $clog2(PAGE_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          refill,
  output logic [DW-1:0] words [PAGE_WORDS]
);

  for (genvar s = 0; s < PAGE_WORDS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || refill) begin
        words[s] <= '1;
      end else if (wr_en && (wr_idx == IW'(s))) begin
        words[s] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/flashpg_array.sv
module flashpg_array #(
  parameter int NUM_PAGES  = 8,
  parameter int PAGE_WORDS = 16,
  parameter int DW         = 32,
  localparam int NUM_WORDS = NUM_PAGES * PAGE_WORDS,
  localparam int MW        = $clog2(NUM_WORDS),
  localparam int PW        = $clog2(NUM_PAGES),
  localparam int IW        = $clog2(PAGE_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_en,
  input  logic          erase_en,
  input  logic          merge,
  input  logic [PW-1:0] prog_page,
  input  logic [DW-1:0] buf_words [PAGE_WORDS],
  input  logic [MW-1:0] rd_idx,
  output logic [DW-1:0] rd_word
);

  logic [DW-1:0] mem [NUM_WORDS];
  logic [MW-1:0] base_idx;

  assign base_idx = {prog_page, {IW{1'b0}}};
  assign rd_word  = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n || erase_en) begin
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '1;
    end else if (prog_en) begin
      for (int w = 0; w < PAGE_WORDS; w++) begin
        if (merge) mem[base_idx + MW'(w)] <= mem[base_idx + MW'(w)] & buf_words[w];
        else       mem[base_idx + MW'(w)] <= buf_words[w];
      end
    end
  end

endmodule

// File: rtl/flashpg_ctrl.sv
module flashpg_ctrl
  import flashpg_pkg::*;
#(
  parameter int NUM_PAGES        = 8,
  parameter int PAGES_PER_REGION = 2,
  parameter int LATENCY          = 32,
  parameter int DW               = 32,
  localparam int NUM_REGIONS     = NUM_PAGES / PAGES_PER_REGION,
  localparam int RW              = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int PW              = $clog2(NUM_PAGES),
  localparam int CW              = $clog2(LATENCY + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_wr,
  input  logic [DW-1:0]          cmd_data,
  input  logic                   mode_merge,
  input  logic                   stat_rd,
  output logic                   busy,
  output logic                   prog_en,
  output logic                   erase_en,
  output logic                   merge,
  output logic [PW-1:0]          prog_page,
  output logic [NUM_REGIONS-1:0] lock_bits,
  output logic                   prog_err,
  output logic                   lock_err
);

  logic [7:0]  f_key, f_page;
  logic [11:0] f_rsv;
  logic [3:0]  f_op;

  assign f_key  = cmd_data[31:24];
  assign f_page = cmd_data[15:8];
  assign f_rsv  = {cmd_data[23:16], cmd_data[7:4]};
  assign f_op   = cmd_data[3:0];

  logic op_known, is_prog, needs_page, page_ok, region_locked, lock_hit, bad, go;
  logic [RW-1:0] tgt_region;

  always_comb begin
    is_prog    = (f_op == OP_PROG) || (f_op == OP_PROG_LOCK);
    needs_page = is_prog || (f_op == OP_LOCK) || (f_op == OP_UNLOCK);
    op_known   = needs_page || (f_op == OP_ERASE_ALL);
    page_ok    = int'(f_page) < NUM_PAGES;
    tgt_region = RW'(int'(f_page) / PAGES_PER_REGION);
    region_locked = page_ok && lock_bits[tgt_region];
    lock_hit   = (is_prog && region_locked) || ((f_op == OP_ERASE_ALL) && (|lock_bits));
    bad        = busy || (f_key != CMD_KEY) || (f_rsv != '0) || !op_known ||
                 (needs_page && !page_ok);
    go         = cmd_wr && !bad && !lock_hit;
  end

  logic [CW-1:0] cnt_q;
  flash_op_e     op_q;
  logic [RW-1:0] region_q;
  logic          done;

  assign done     = busy && (cnt_q == '0);
  assign prog_en  = done && ((op_q == OP_PROG) || (op_q == OP_PROG_LOCK));
  assign erase_en = done && (op_q == OP_ERASE_ALL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt_q     <= '0;
      op_q      <= OP_PROG;
      region_q  <= '0;
      prog_page <= '0;
      merge     <= 1'b0;
    end else if (go) begin
      busy      <= 1'b1;
      cnt_q     <= CW'(LATENCY - 1);
      op_q      <= flash_op_e'(f_op);
      region_q  <= tgt_region;
      prog_page <= f_page[PW-1:0];
      merge     <= mode_merge;
    end else if (busy) begin
      if (done) busy  <= 1'b0;
      else      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_bits <= '0;
    end else if (done) begin
      if ((op_q == OP_PROG_LOCK) || (op_q == OP_LOCK)) lock_bits[region_q] <= 1'b1;
      else if (op_q == OP_UNLOCK)                      lock_bits[region_q] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_err <= 1'b0;
      lock_err <= 1'b0;
    end else begin
      prog_err <= (prog_err && !stat_rd) || (cmd_wr && bad);
      lock_err <= (lock_err && !stat_rd) || (cmd_wr && !bad && lock_hit);
    end
  end

endmodule

// File: rtl/flashpg_top.sv
module flashpg_top
  import flashpg_pkg::*;
#(
  parameter int NUM_PAGES        = 8,
  parameter int PAGE_WORDS       = 16,
  parameter int PAGES_PER_REGION = 2,
  parameter int LATENCY          = 32,
  localparam int DW              = 32,
  localparam int NUM_WORDS       = NUM_PAGES * PAGE_WORDS,
  localparam int NUM_REGIONS     = NUM_PAGES / PAGES_PER_REGION,
  localparam int MW              = $clog2(NUM_WORDS),
  localparam int IW              = $clog2(PAGE_WORDS),
  localparam int PW              = $clog2(NUM_PAGES),
  localparam int ADDR_W          = MW + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              irq
);

  logic is_reg, reg_hit, full_word, acc;
  logic [1:0] reg_sel;
  logic busy, prog_en, erase_en, merge, prog_err, lock_err;
  logic [PW-1:0] prog_page;
  logic [NUM_REGIONS-1:0] lock_bits;
  logic [1:0] mode_q;
  logic buf_wr, cmd_wr, stat_rd;
  logic [DW-1:0] buf_words [PAGE_WORDS];
  logic [DW-1:0] arr_word, stat_word, rd_mux;

  assign is_reg    = req_addr[ADDR_W-1];
  assign reg_hit   = is_reg && (req_addr[ADDR_W-2:4] == '0);
  assign reg_sel   = req_addr[3:2];
  assign full_word = (req_size == SIZE_WORD) && (req_addr[1:0] == 2'b00);
  assign req_ready = is_reg || !busy;
  assign acc       = req_valid && req_ready;

  assign buf_wr  = acc && req_write && !is_reg && full_word;
  assign cmd_wr  = acc && req_write && reg_hit && (reg_sel == REG_CMD) && full_word;
  assign stat_rd = acc && !req_write && reg_hit && (reg_sel == REG_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= '0;
    else if (acc && req_write && reg_hit && (reg_sel == REG_MODE) && full_word)
      mode_q <= req_wdata[1:0];
  end

  flashpg_latch #(.PAGE_WORDS(PAGE_WORDS), .DW(DW)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (buf_wr),
    .wr_idx (req_addr[IW+1:2]),
    .wr_data(req_wdata),
    .refill (prog_en),
    .words  (buf_words)
  );

  flashpg_array #(.NUM_PAGES(NUM_PAGES), .PAGE_WORDS(PAGE_WORDS), .DW(DW)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_en  (prog_en),
    .erase_en (erase_en),
    .merge    (merge),
    .prog_page(prog_page),
    .buf_words(buf_words),
    .rd_idx   (req_addr[MW+1:2]),
    .rd_word  (arr_word)
  );

  flashpg_ctrl #(
    .NUM_PAGES(NUM_PAGES), .PAGES_PER_REGION(PAGES_PER_REGION),
    .LATENCY(LATENCY), .DW(DW)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_data  (req_wdata),
    .mode_merge(mode_q[1]),
    .stat_rd   (stat_rd),
    .busy      (busy),
    .prog_en   (prog_en),
    .erase_en  (erase_en),
    .merge     (merge),
    .prog_page (prog_page),
    .lock_bits (lock_bits),
    .prog_err  (prog_err),
    .lock_err  (lock_err)
  );

  always_comb begin
    stat_word = '0;
    stat_word[STAT_READY] = !busy;
    stat_word[STAT_PERR]  = prog_err;
    stat_word[STAT_LERR]  = lock_err;
    stat_word[STAT_LOCK +: NUM_REGIONS] = lock_bits;
    if (!is_reg)                              rd_mux = arr_word;
    else if (!reg_hit)                        rd_mux = '0;
    else if (reg_sel == REG_MODE)             rd_mux = {{(DW-2){1'b0}}, mode_q};
    else if (reg_sel == REG_STAT)             rd_mux = stat_word;
    else                                      rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc && !req_write;
      if (acc && !req_write) rsp_rdata <= rd_mux;
    end
  end

  assign irq = !busy && mode_q[0];

endmodule

// File: rtl/flashpg_checker.sv
module flashpg_checker #(
  parameter int ADDR_W  = 10,
  parameter int LATENCY = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              irq,
  input logic              busy,
  input logic              cmd_wr,
  input logic              prog_err
);

  localparam int LW = $clog2(LATENCY + 2);
  logic [LW-1:0] busy_len;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) busy_len <= '0;
    else                 busy_len <= busy_len + 1'b1;
  end

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == LW'(LATENCY)));

  p_start_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_wr));

  p_irq_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !irq);

  p_busy_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> prog_err);

  p_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_addr[ADDR_W-1] && busy) |-> !req_ready);

  p_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));

endmodule

bind flashpg_top flashpg_checker #(.ADDR_W(ADDR_W), .LATENCY(LATENCY)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_write(req_write),
  .req_addr (req_addr),
  .rsp_valid(rsp_valid),
  .irq      (irq),
  .busy     (busy),
  .cmd_wr   (cmd_wr),
  .prog_err (prog_err)
);

// File: tb/flashpg_top_tb_top.sv
module flashpg_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  flashpg_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  localparam logic [9:0] A_MODE = 10'h200;
  localparam logic [9:0] A_CMD  = 10'h204;
  localparam logic [9:0] A_STAT = 10'h208;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // All bus tasks start and end at a falling edge.
  task automatic bus_wr(input logic [9:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_size = sz;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_size = 2'd2;
  endtask

  task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = 2'd2;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!rsp_valid) begin
      checks++; fails++;
      $display("FAIL R12: rsp_valid actual 0 expected 1");
    end
    d = rsp_rdata;
  endtask

  function automatic logic [31:0] cmd(input logic [7:0] pg, input logic [3:0] op);
    return {8'h5A, 8'h00, pg, 4'h0, op};
  endfunction

  function automatic logic [9:0] maddr(input int pg, input int w);
    return 10'(pg * 64 + w * 4);
  endfunction

  task automatic wait_done();
    int n = 0;
    while (!irq && n < 200) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_rd(A_STAT, d);   check("R3 reset status", d, 32'h1);
    check("R4 irq disabled", {31'b0, irq}, 32'h0);
    bus_rd(maddr(0, 0), d); check("R7 reset array", d, 32'hFFFF_FFFF);
    bus_wr(A_MODE, 32'h1);
    check("R4 irq enabled while ready", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_wrap_program();
    logic [31:0] d;
    for (int i = 0; i < 16; i++) bus_wr(maddr(5, i), 32'hA000_0000 + i);
    bus_wr(A_CMD, cmd(8'd0, 4'h1));
    repeat (31) @(negedge clk);
    check("R3 busy through cycle 31", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R3 ready after 32 cycles", {31'b0, irq}, 32'h1);
    bus_rd(maddr(0, 0), d);  check("R1 slot 0 to page 0", d, 32'hA000_0000);
    bus_rd(maddr(0, 15), d); check("R1 slot 15 to page 0", d, 32'hA000_000F);
    bus_rd(maddr(5, 0), d);  check("R1 page 5 untouched", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_busy_cmd();
    logic [31:0] d;
    bus_wr(A_CMD, cmd(8'd1, 4'h1));
    bus_rd(A_STAT, d); check("R3 ready cleared", d, 32'h0);
    bus_wr(A_CMD, cmd(8'd3, 4'h1));
    wait_done();
    bus_rd(A_STAT, d); check("R11 busy command flagged", d, 32'h3);
    bus_rd(A_STAT, d); check("R10 flags cleared by read", d, 32'h1);
    bus_rd(maddr(1, 3), d); check("R13 buffer refilled", d, 32'hFFFF_FFFF);
    bus_rd(maddr(3, 0), d); check("R11 ignored command", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_subword();
    logic [31:0] d;
    bus_wr(maddr(0, 3), 32'h1234_5678, 2'd0);
    bus_wr(maddr(0, 3), 32'h1234_5678, 2'd1);
    bus_wr(maddr(0, 5) + 10'd2, 32'h1234_5678, 2'd2);
    bus_wr(maddr(0, 4), 32'h0BAD_F00D);
    bus_wr(A_CMD, cmd(8'd2, 4'h1));
    wait_done();
    bus_rd(maddr(2, 3), d); check("R2 sub-word ignored", d, 32'hFFFF_FFFF);
    bus_rd(maddr(2, 5), d); check("R2 misaligned ignored", d, 32'hFFFF_FFFF);
    bus_rd(maddr(2, 4), d); check("R2 word accepted", d, 32'h0BAD_F00D);
  endtask

  task automatic t_errors();
    logic [31:0] d;
    bus_wr(maddr(0, 0), 32'h7777_7777);
    bus_wr(A_CMD, {8'hA5, 8'h00, 8'd3, 4'h0, 4'h1});
    bus_rd(A_STAT, d); check("R5 bad key", d, 32'h3);
    bus_wr(A_CMD, cmd(8'd3, 4'h5));
    bus_rd(A_STAT, d); check("R5 bad opcode", d, 32'h3);
    bus_wr(A_CMD, cmd(8'd8, 4'h1));
    bus_rd(A_STAT, d); check("R5 page out of range", d, 32'h3);
    bus_wr(A_CMD, cmd(8'd3, 4'h1) | 32'h0001_0000);
    bus_rd(A_STAT, d); check("R5 reserved bits", d, 32'h3);
    bus_rd(maddr(3, 0), d); check("R5 array untouched", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    bus_wr(maddr(0, 0), 32'h1111_1111);
    bus_wr(A_CMD, cmd(8'd4, 4'h2));
    wait_done();
    bus_rd(A_STAT, d); check("R8 auto lock region 2", d, 32'h0004_0001);
    bus_rd(maddr(4, 0), d); check("R8 data programmed", d, 32'h1111_1111);
    bus_wr(maddr(0, 0), 32'h2222_2222);
    bus_wr(A_CMD, cmd(8'd5, 4'h1));
    bus_rd(A_STAT, d); check("R6 lock error", d, 32'h0004_0005);
    bus_rd(maddr(5, 0), d); check("R6 locked page untouched", d, 32'hFFFF_FFFF);
    bus_wr(A_CMD, cmd(8'd0, 4'h8));
    bus_rd(A_STAT, d); check("R7 erase refused when locked", d, 32'h0004_0005);
    bus_rd(maddr(0, 0), d); check("R7 array kept", d, 32'hA000_0000);
    bus_wr(A_CMD, cmd(8'd5, 4'h4));
    wait_done();
    bus_rd(A_STAT, d); check("R6 unlock", d, 32'h1);
    bus_wr(A_CMD, cmd(8'd5, 4'h1));
    wait_done();
    bus_rd(maddr(5, 0), d); check("R6 program after unlock", d, 32'h2222_2222);
    bus_wr(A_CMD, cmd(8'd6, 4'h3));
    wait_done();
    bus_rd(A_STAT, d); check("R6 explicit lock region 3", d, 32'h0008_0001);
    bus_wr(A_CMD, cmd(8'd7, 4'h4));
    wait_done();
    bus_rd(A_STAT, d); check("R6 explicit unlock region 3", d, 32'h1);
  endtask

  task automatic t_partial();
    logic [31:0] d;
    bus_wr(A_MODE, 32'h3);
    bus_wr(maddr(0, 0), 32'hCAFE_FFFF);
    bus_wr(A_CMD, cmd(8'd6, 4'h1)); wait_done();
    bus_wr(maddr(0, 1), 32'hDECA_FFFF);
    bus_wr(A_CMD, cmd(8'd6, 4'h1)); wait_done();
    bus_rd(maddr(6, 0), d); check("R9 first part kept", d, 32'hCAFE_FFFF);
    bus_rd(maddr(6, 1), d); check("R9 second part", d, 32'hDECA_FFFF);
    bus_wr(maddr(0, 0), 32'h0F0F_FFFF);
    bus_wr(A_CMD, cmd(8'd6, 4'h1)); wait_done();
    bus_rd(maddr(6, 0), d); check("R9 bitwise AND", d, 32'h0A0E_FFFF);
    bus_wr(A_MODE, 32'h1);
    bus_wr(maddr(0, 2), 32'h5555_AAAA);
    bus_wr(A_CMD, cmd(8'd6, 4'h1)); wait_done();
    bus_rd(maddr(6, 0), d); check("R9 page erased first", d, 32'hFFFF_FFFF);
    bus_rd(maddr(6, 2), d); check("R9 new data", d, 32'h5555_AAAA);
  endtask

  task automatic t_stall_erase();
    logic [31:0] d;
    bus_wr(A_CMD, cmd(8'd7, 4'h1));
    req_valid = 1'b1; req_write = 1'b0; req_addr = maddr(0, 0);
    #1 check("R12 memory stalled", {31'b0, req_ready}, 32'h0);
    req_addr = A_MODE;
    #1 check("R12 register not stalled", {31'b0, req_ready}, 32'h1);
    req_valid = 1'b0;
    @(negedge clk);
    wait_done();
    bus_wr(A_CMD, cmd(8'd0, 4'h8));
    wait_done();
    bus_rd(maddr(0, 0), d); check("R7 erase all page 0", d, 32'hFFFF_FFFF);
    bus_rd(maddr(6, 2), d); check("R7 erase all page 6", d, 32'hFFFF_FFFF);
    bus_rd(maddr(4, 0), d); check("R7 erase all page 4", d, 32'hFFFF_FFFF);
    bus_wr(A_MODE, 32'h0);
    check("R4 irq off when disabled", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wrap_program();
    t_busy_cmd();
    t_subword();
    t_errors();
    t_lock();
    t_partial();
    t_stall_erase();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule